// File: doc/BRIEF.md
# Boost PFC Switching-Frequency and Conduction-Mode Selector

This block picks the operating mode of a boost power-factor-correction stage once per switching cycle. There are five modes. A constant-peak region covers the low-voltage part of the line cycle near each zero crossing. Three discontinuous-conduction (DCM) modes run at 125, 250 and 500 kHz. A continuous-conduction (CCM) mode runs at 1 MHz. The choice depends on the quantized instantaneous input voltage, on a bit that selects the low or high output-voltage range, and on the commanded peak current. The command is compared against per-frequency thresholds. The thresholds come from two small writable tables, one for each output range, and the input voltage picks the entry.

The block also produces the turn-on (set) pulse for the power switch.

- In constant-peak and DCM modes, the pulse comes from a divider running on the 50 MHz system clock.
- In CCM, the pulse is the pulse of an external off-time generator, passed through.

Mode changes are applied only on a set pulse, so every switching period is whole. The block also outputs a clamped copy of the peak command, limited by the current mode. The peak-current arithmetic and the off-time generator itself are outside the block.

Top module: `pfc_freq_mode_sel`

## Requirements
- R1: After reset, mode_o is 0 (constant-peak), div_sel_o is 0 and set_o is 0. Mode codes are: 0 constant-peak, 1 DCM 125 kHz, 2 DCM 250 kHz, 3 DCM 500 kHz, 4 CCM.
- R2: At a switching boundary, the next mode is 0 whenever vin_i is below the low-voltage level, from any mode. The level is 20 when vrange_i is 0 and 40 when vrange_i is 1.
- R3: From mode 0, with vin_i at or above the level and bcm_over_i low, the next boundary enters mode 1.
- R4: In modes 1 to 3, a peak command strictly greater than the up-threshold of the current mode raises the mode by exactly one step at the next boundary. The up-threshold is table step index mode-1.
- R5: In modes 2 to 4, a peak command at or below the up-threshold of the mode below lowers the mode by exactly one step. That threshold is table step index mode-2. An upward step takes priority over a downward one.
- R6: When bcm_over_i is high at a boundary and vin_i is at or above the level, the next mode is 4 from any mode, with no intermediate modes.
- R7: In modes 0 to 3, set_o is a one-cycle pulse every 400, 400, 200 and 100 clocks respectively. div_sel_o is 0, 0, 1 and 2. otg_set_i has no effect on set_o in these modes.
- R8: In mode 4, div_sel_o is 3 and set_o equals otg_set_i delayed by one clock.
- R9: mode_o changes only in the cycle in which set_o is high.
- R10: ipk_o is ipk_cmd_i clamped to at least 100 and at most a cap. The cap is 1000 in mode 1, 1200 in mode 2 and 3000 otherwise (units of mA).
- R11: There are two threshold tables, selected by vrange_i. Each is addressed by bucket vin_i[8:6] and step index 0..2. After reset every entry holds 1000, 1200 or 3000 for step 0, 1 or 2. A write through the tbl_* port takes effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vin_i | input | 9 | Quantized rectified input voltage, 1 V per LSB |
| vrange_i | input | 1 | Output-voltage range: 0 low, 1 high |
| ipk_cmd_i | input | 12 | Commanded peak current, mA |
| bcm_over_i | input | 1 | Command exceeds the boundary-conduction threshold |
| otg_set_i | input | 1 | Set pulse from the off-time generator |
| tbl_we_i | input | 1 | Threshold table write enable |
| tbl_range_i | input | 1 | Table select for write |
| tbl_bkt_i | input | 3 | Voltage bucket for write |
| tbl_step_i | input | 2 | Step index (0..2) for write |
| tbl_data_i | input | 12 | Threshold value, mA |
| mode_o | output | 3 | Current mode code |
| div_sel_o | output | 2 | Set source: 0 /400, 1 /200, 2 /100, 3 off-time generator |
| set_o | output | 1 | Turn-on set pulse |
| ipk_o | output | 12 | Clamped peak command, mA |

## Verification
A directed sweep first walks the mode ladder up one step per cycle and back down at a fixed input voltage. This separates single stepping from skipping, and strict-greater from greater-or-equal comparisons. Input voltages just below and above the 20 and 40 levels, with both range bits, show whether the low-voltage gate uses the right range. A boundary-conduction flag raised from the 125 kHz mode shows whether the jump to CCM is direct. Changed table entries used at the same voltage under the two range bits show that the tables are separate. Random voltages, commands and flags follow, scored against a model of the mode ladder, together with set-pulse spacing and injected off-time pulses in DCM.

// File: rtl/pfc_fsel_pkg.sv
package pfc_fsel_pkg;
  typedef enum logic [2:0] {
    MODE_CPK  = 3'd0,
    MODE_D125 = 3'd1,
    MODE_D250 = 3'd2,
    MODE_D500 = 3'd3,
    MODE_CCM  = 3'd4
  } fmode_e;

  function automatic logic [1:0] div_sel_of(fmode_e m);
    case (m)
      MODE_D250: return 2'd1;
      MODE_D500: return 2'd2;
      MODE_CCM:  return 2'd3;
      default:   return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/pfc_thr_table.sv
module pfc_thr_table #(
  parameter int IW    = 12,
  parameter int BKT_W = 3,
  parameter int THR0  = 1000,
  parameter int THR1  = 1200,
  parameter int THR2  = 3000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             wr_rng_i,
  input  logic [BKT_W-1:0] wr_bkt_i,
  input  logic [1:0]       wr_step_i,
  input  logic [IW-1:0]    wr_data_i,
  input  logic             rd_rng_i,
  input  logic [BKT_W-1:0] rd_bkt_i,
  input  logic [1:0]       rd_up_step_i,
  input  logic [1:0]       rd_dn_step_i,
  output logic [IW-1:0]    up_thr_o,
  output logic [IW-1:0]    dn_thr_o
);
  localparam int AW = 1 + BKT_W + 2;
  localparam int NE = 1 << AW;

  logic [IW-1:0] ent_q [NE];
  logic [AW-1:0] wr_addr, up_addr, dn_addr;

  assign wr_addr = {wr_rng_i, wr_bkt_i, wr_step_i};
  assign up_addr = {rd_rng_i, rd_bkt_i, rd_up_step_i};
  assign dn_addr = {rd_rng_i, rd_bkt_i, rd_dn_step_i};

  for (genvar e = 0; e < NE; e++) begin : g_ent
    localparam int STEP = e % 4;
    localparam int DEF  = (STEP == 0) ? THR0 : (STEP == 1) ? THR1 : THR2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ent_q[e] <= IW'(DEF);
      else if (we_i && wr_addr == AW'(e) && wr_step_i != 2'd3) ent_q[e] <= wr_data_i;
    end
  end

  assign up_thr_o = ent_q[up_addr];
  assign dn_thr_o = ent_q[dn_addr];
endmodule

// File: rtl/pfc_mode_next.sv
module pfc_mode_next
  import pfc_fsel_pkg::*;
#(
  parameter int VW     = 9,
  parameter int IW     = 12,
  parameter int VCP_LO = 20,
  parameter int VCP_HI = 40
) (
  input  fmode_e        cur_i,
  input  logic [VW-1:0] vin_i,
  input  logic          rng_i,
  input  logic [IW-1:0] ipk_i,
  input  logic          bcm_i,
  input  logic [IW-1:0] up_thr_i,
  input  logic [IW-1:0] dn_thr_i,
  output logic [1:0]    up_step_o,
  output logic [1:0]    dn_step_o,
  output fmode_e        nxt_o
);
  logic low_v, go_up, go_dn;

  assign low_v = vin_i < (rng_i ? VW'(VCP_HI) : VW'(VCP_LO));
  assign go_up = ipk_i > up_thr_i;
  assign go_dn = ipk_i <= dn_thr_i;

  always_comb begin
    case (cur_i)
      MODE_D250: begin up_step_o = 2'd1; dn_step_o = 2'd0; end
      MODE_D500: begin up_step_o = 2'd2; dn_step_o = 2'd1; end
      MODE_CCM:  begin up_step_o = 2'd2; dn_step_o = 2'd2; end
      default:   begin up_step_o = 2'd0; dn_step_o = 2'd0; end
    endcase
  end

  always_comb begin
    nxt_o = cur_i;
    if (low_v)      nxt_o = MODE_CPK;
    else if (bcm_i) nxt_o = MODE_CCM;
    else begin
      case (cur_i)
        MODE_CPK:  nxt_o = MODE_D125;
        MODE_D125: if (go_up) nxt_o = MODE_D250;
        MODE_D250: if (go_up) nxt_o = MODE_D500;
                   else if (go_dn) nxt_o = MODE_D125;
        MODE_D500: if (go_up) nxt_o = MODE_CCM;
                   else if (go_dn) nxt_o = MODE_D250;
        MODE_CCM:  if (go_dn) nxt_o = MODE_D500;
        default:   nxt_o = MODE_CPK;
      endcase
    end
  end
endmodule

// File: rtl/pfc_set_gen.sv
module pfc_set_gen #(
  parameter int DIV_A = 400,
  parameter int DIV_B = 200,
  parameter int DIV_C = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] div_sel_i,
  input  logic       otg_set_i,
  output logic       bound_o,
  output logic       set_o
);
  localparam int CW = $clog2(DIV_A);

  logic [CW-1:0] cnt_q, lim;
  logic          ccm, tick;

  assign ccm = div_sel_i == 2'd3;

  always_comb begin
    case (div_sel_i)
      2'd0:    lim = CW'(DIV_A - 1);
      2'd1:    lim = CW'(DIV_B - 1);
      default: lim = CW'(DIV_C - 1);
    endcase
  end

  assign tick    = !ccm && cnt_q == lim;
  assign bound_o = ccm ? otg_set_i : tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      set_o <= 1'b0;
    end else begin
      set_o <= bound_o;
      if (ccm || tick) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pfc_pk_clamp.sv
module pfc_pk_clamp
  import pfc_fsel_pkg::*;
#(
  parameter int IW      = 12,
  parameter int IMIN    = 100,
  parameter int IMAX    = 3000,
  parameter int CAP_125 = 1000,
  parameter int CAP_250 = 1200
) (
  input  fmode_e        mode_i,
  input  logic [IW-1:0] ipk_i,
  output logic [IW-1:0] ipk_o
);
  logic [IW-1:0] cap;

  always_comb begin
    case (mode_i)
      MODE_D125: cap = IW'(CAP_125);
      MODE_D250: cap = IW'(CAP_250);
      default:   cap = IW'(IMAX);
    endcase
    if (ipk_i < IW'(IMIN)) ipk_o = IW'(IMIN);
    else if (ipk_i > cap)  ipk_o = cap;
    else                   ipk_o = ipk_i;
  end
endmodule

// File: rtl/pfc_freq_mode_sel.sv
module pfc_freq_mode_sel
  import pfc_fsel_pkg::*;
#(
  parameter int VW     = 9,
  parameter int IW     = 12,
  parameter int BKT_W  = 3,
  parameter int VCP_LO = 20,
  parameter int VCP_HI = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VW-1:0]    vin_i,
  input  logic             vrange_i,
  input  logic [IW-1:0]    ipk_cmd_i,
  input  logic             bcm_over_i,
  input  logic             otg_set_i,
  input  logic             tbl_we_i,
  input  logic             tbl_range_i,
  input  logic [BKT_W-1:0] tbl_bkt_i,
  input  logic [1:0]       tbl_step_i,
  input  logic [IW-1:0]    tbl_data_i,
  output logic [2:0]       mode_o,
  output logic [1:0]       div_sel_o,
  output logic             set_o,
  output logic [IW-1:0]    ipk_o
);
  fmode_e        mode_q, mode_nxt;
  logic [1:0]    up_step, dn_step;
  logic [IW-1:0] up_thr, dn_thr;
  logic          bound;

  pfc_thr_table #(.IW(IW), .BKT_W(BKT_W)) u_tbl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (tbl_we_i),
    .wr_rng_i    (tbl_range_i),
    .wr_bkt_i    (tbl_bkt_i),
    .wr_step_i   (tbl_step_i),
    .wr_data_i   (tbl_data_i),
    .rd_rng_i    (vrange_i),
    .rd_bkt_i    (vin_i[VW-1 -: BKT_W]),
    .rd_up_step_i(up_step),
    .rd_dn_step_i(dn_step),
    .up_thr_o    (up_thr),
    .dn_thr_o    (dn_thr)
  );

  pfc_mode_next #(.VW(VW), .IW(IW), .VCP_LO(VCP_LO), .VCP_HI(VCP_HI)) u_nxt (
    .cur_i    (mode_q),
    .vin_i    (vin_i),
    .rng_i    (vrange_i),
    .ipk_i    (ipk_cmd_i),
    .bcm_i    (bcm_over_i),
    .up_thr_i (up_thr),
    .dn_thr_i (dn_thr),
    .up_step_o(up_step),
    .dn_step_o(dn_step),
    .nxt_o    (mode_nxt)
  );

  pfc_set_gen u_set (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_sel_i(div_sel_o),
    .otg_set_i(otg_set_i),
    .bound_o  (bound),
    .set_o    (set_o)
  );

  pfc_pk_clamp #(.IW(IW)) u_clamp (
    .mode_i(mode_q),
    .ipk_i (ipk_cmd_i),
    .ipk_o (ipk_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= MODE_CPK;
    else if (bound) mode_q <= mode_nxt;
  end

  assign div_sel_o = div_sel_of(mode_q);
  assign mode_o    = mode_q;
endmodule

// File: rtl/pfc_fsel_chk.sv
module pfc_fsel_chk #(
  parameter int VW     = 9,
  parameter int IW     = 12,
  parameter int VCP_LO = 20,
  parameter int VCP_HI = 40
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [VW-1:0] vin_i,
  input logic          vrange_i,
  input logic          bcm_over_i,
  input logic [2:0]    mode_o,
  input logic          set_o,
  input logic [IW-1:0] ipk_o
);
  logic low_v;
  assign low_v = vin_i < (vrange_i ? VW'(VCP_HI) : VW'(VCP_LO));

  a_r9_change_on_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> set_o);

  a_r2_low_to_cpk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_o && $past(low_v)) |-> mode_o == 3'd0);

  a_r6_bcm_to_ccm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_o && $past(bcm_over_i) && !$past(low_v)) |-> mode_o == 3'd4);

  a_r4_single_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_o && !$past(bcm_over_i)) |-> ({1'b0, mode_o} <= {1'b0, $past(mode_o)} + 4'd1));

  a_r7_dcm_pulse_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_o && mode_o != 3'd4) |=> !set_o);

  a_r10_clamp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipk_o >= IW'(100)) && (ipk_o <= IW'(3000)));

  a_r10_cap_125: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1) |-> ipk_o <= IW'(1000));
endmodule

bind pfc_freq_mode_sel pfc_fsel_chk #(.VW(VW), .IW(IW), .VCP_LO(VCP_LO), .VCP_HI(VCP_HI)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .vin_i     (vin_i),
  .vrange_i  (vrange_i),
  .bcm_over_i(bcm_over_i),
  .mode_o    (mode_o),
  .set_o     (set_o),
  .ipk_o     (ipk_o)
);

// File: tb/pfc_freq_mode_sel_tb.sv
module pfc_freq_mode_sel_tb_top;
  localparam int CLK_NS = 20;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [8:0]  vin_i = '0;
  logic        vrange_i = 1'b0, bcm_over_i = 1'b0, otg_set_i = 1'b0;
  logic        tbl_we_i = 1'b0, tbl_range_i = 1'b0;
  logic [2:0]  tbl_bkt_i = '0;
  logic [1:0]  tbl_step_i = '0;
  logic [11:0] ipk_cmd_i = '0, tbl_data_i = '0;
  logic [2:0]  mode_o;
  logic [1:0]  div_sel_o;
  logic        set_o;
  logic [11:0] ipk_o;

  int n_chk = 0, n_err = 0;
  int thr_sh [2][8][3];
  int cur = 0;
  bit first_per = 1'b1;
  bit done = 1'b0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  pfc_freq_mode_sel dut_i (.*);

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lim_of(int m);
    return (m == 2) ? 200 : (m == 3) ? 100 : 400;
  endfunction

  function automatic int dsel_of(int m);
    return (m == 4) ? 3 : (m == 3) ? 2 : (m == 2) ? 1 : 0;
  endfunction

  function automatic int clamp_of(int m, int ipk);
    int cap = (m == 1) ? 1000 : (m == 2) ? 1200 : 3000;
    if (ipk < 100) return 100;
    if (ipk > cap) return cap;
    return ipk;
  endfunction

  function automatic int model(int c, int vin, int rng, int ipk, bit bcm, output string tag);
    int b = vin / 64;
    if (vin < (rng ? 40 : 20)) begin tag = "R2"; return 0; end
    if (bcm) begin tag = "R6"; return 4; end
    if (c == 0) begin tag = "R3"; return 1; end
    if (c <= 3 && ipk > thr_sh[rng][b][c-1]) begin tag = "R4 R11"; return c + 1; end
    if (c >= 2 && ipk <= thr_sh[rng][b][c-2]) begin tag = "R5 R11"; return c - 1; end
    tag = "R4 R5 hold";
    return c;
  endfunction

  task automatic wr(int rng, int bkt, int step, int d);
    @(negedge clk_i);
    tbl_we_i = 1'b1; tbl_range_i = rng[0]; tbl_bkt_i = 3'(bkt);
    tbl_step_i = 2'(step); tbl_data_i = 12'(d);
    @(negedge clk_i);
    tbl_we_i = 1'b0;
    thr_sh[rng][bkt][step] = d;
  endtask

  // inputs are applied at a negedge right after the previous boundary
  task automatic run_step(int vin, int rng, int ipk, bit bcm);
    int cnt = 0;
    int expm;
    string tag;
    vin_i = 9'(vin); vrange_i = rng[0]; ipk_cmd_i = 12'(ipk); bcm_over_i = bcm;
    expm = model(cur, vin, rng, ipk, bcm, tag);
    if (cur == 4) begin
      repeat (3) @(negedge clk_i);
      chk(set_o == 1'b0 && mode_o == 3'd4, "R9 hold in CCM", int'(mode_o), 4);
      otg_set_i = 1'b1;
      @(negedge clk_i);
      otg_set_i = 1'b0;
      chk(set_o == 1'b1, "R8 otg passthrough", int'(set_o), 1);
    end else begin
      do begin
        @(negedge clk_i);
        cnt++;
        if (cnt == 5) otg_set_i = 1'b1;
        if (cnt == 6) otg_set_i = 1'b0;
        if (!set_o && mode_o != 3'(cur)) chk(1'b0, "R9 early change", int'(mode_o), cur);
      end while (!set_o && cnt < 1000);
      if (!first_per) chk(cnt == lim_of(cur), "R7 set period", cnt, lim_of(cur));
      first_per = 1'b0;
    end
    chk(int'(mode_o) == expm, tag, int'(mode_o), expm);
    chk(int'(div_sel_o) == dsel_of(expm), "R7 R8 div_sel", int'(div_sel_o), dsel_of(expm));
    chk(int'(ipk_o) == clamp_of(expm, ipk), "R10 clamp", int'(ipk_o), clamp_of(expm, ipk));
    cur = int'(mode_o);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < 8; b++) begin
        thr_sh[r][b][0] = 1000; thr_sh[r][b][1] = 1200; thr_sh[r][b][2] = 3000;
      end
    repeat (3) @(negedge clk_i);
    chk(mode_o == 3'd0, "R1 reset mode", int'(mode_o), 0);
    chk(set_o == 1'b0, "R1 reset set", int'(set_o), 0);
    chk(div_sel_o == 2'd0, "R1 reset div_sel", int'(div_sel_o), 0);
    rst_ni = 1'b1;
    wr(1, 4, 0, 300);
    // directed
    run_step(10, 0, 500, 0);
    run_step(30, 1, 500, 0);
    run_step(19, 0, 500, 0);
    run_step(20, 0, 500, 0);
    run_step(200, 0, 1001, 0);
    run_step(200, 0, 1201, 0);
    run_step(200, 0, 3001, 0);
    run_step(200, 0, 3000, 0);
    run_step(200, 0, 1200, 0);
    run_step(200, 0, 1000, 0);
    run_step(200, 0, 500, 1);
    run_step(100, 1, 500, 0);
    run_step(300, 1, 400, 0);
    run_step(300, 1, 400, 0);
    run_step(300, 1, 250, 0);
    run_step(300, 1, 350, 0);
    run_step(300, 0, 350, 0);
    run_step(39, 1, 350, 1);
    run_step(40, 1, 50, 0);
    // random
    for (int i = 0; i < 150; i++) begin
      int v = (($urandom % 8) == 0) ? int'($urandom % 45) : int'($urandom % 512);
      int p = int'($urandom % 3600);
      bit bc = (($urandom % 10) == 0);
      run_step(v, int'($urandom % 2), p, bc);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule